// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a write-through cache and the next memory level. It takes word writes from the cache side, each with a word address, a data word and per-byte enables. When a slot is free the write is taken in the same cycle and reported done, so the store costs the processor no further time. Held writes go to memory in the background, oldest first, one per completed valid/ready handshake.

A new write whose word address is already held in a slot that is not being drained is folded into that slot byte by byte. This saves a slot and a later memory transaction. The oldest slot is the one offered downstream, so it is never changed, and a write to its address opens a fresh slot instead. The writer sees a stall only when all slots are taken, the write cannot merge and no slot frees in that cycle. An empty flag lets upstream logic wait until every buffered write has reached memory.

Top module: `store_coalesce_buf`

## Requirements
- R1: After reset, `empty` is 1, `mem_valid` is 0 and `in_stall` is 0.
- R2: A write presented while fewer than DEPTH slots are held is accepted in the same cycle: `in_accept`=1 and `in_stall`=0.
- R3: A write whose address equals that of a held slot other than the oldest merges into it. Bytes whose enable bit (bit i covers data bits 8i+7..8i) is set take the new value. The other bytes keep their old value, the slot's enables become the OR of old and new, and no slot is used.
- R4: The oldest held slot is driven on `mem_addr`/`mem_data`/`mem_be` with `mem_valid`=1. A write to its address takes a new slot and leaves it unchanged.
- R5: Slots leave in arrival order, one per cycle with `mem_valid` and `mem_ready` both high. While `mem_ready` is low, the presented slot's fields stay stable.
- R6: With DEPTH slots held, no merge target and no handshake completing, a write sees `in_accept`=0 and `in_stall`=1. A write that can merge is still accepted when the buffer is full.
- R7: With DEPTH slots held and a handshake completing in the same cycle, a new write is accepted without a stall.
- R8: `empty` is 1 exactly when no slot is held, and then `mem_valid` is 0.
- R9: Data bytes whose enable bit was never set in a slot are driven as zero on `mem_data`.
- R10: `in_stall` and `in_accept` are 0 while `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Write request from cache side |
| in_addr | input | ADDR_W | Word address of the write |
| in_data | input | DATA_W | Write data |
| in_be | input | DATA_W/8 | Byte enables |
| in_accept | output | 1 | Write taken this cycle |
| in_stall | output | 1 | Write refused, writer must hold |
| empty | output | 1 | No write held |
| mem_valid | output | 1 | Oldest slot offered downstream |
| mem_addr | output | ADDR_W | Address of offered slot |
| mem_data | output | DATA_W | Data of offered slot |
| mem_be | output | DATA_W/8 | Byte enables of offered slot |
| mem_ready | input | 1 | Downstream takes the offered slot |

## Verification
The hardest case to reach is a full buffer in which a new write and a completed drain fall in the same cycle. This depends on holding `mem_ready` low until all four slots are filled, partly through merges, and then raising it in the cycle that carries the fifth write. The stimulus table fills the buffer with merges into non-oldest slots and a write aimed at the oldest slot's address. A directed step then lines up the drain and the write. The full drain that follows checks the merged bytes, the zeroed disabled bytes and the order in which slots leave.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    localparam int unsigned WB_DEPTH_DFLT  = 4;
    localparam int unsigned WB_ADDR_W_DFLT = 30;
    localparam int unsigned WB_DATA_W_DFLT = 32;

    // index width that stays at least one bit wide
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wbuf_match.sv
module wbuf_match #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned ADDR_W = 30,
    parameter int unsigned IDX_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DEPTH-1:0]        ent_valid,
    input  logic [DEPTH-1:0]        ent_skip,
    input  logic [DEPTH*ADDR_W-1:0] ent_addr,
    input  logic [ADDR_W-1:0]       probe_addr,
    output logic                    hit,
    output logic [IDX_W-1:0]        hit_idx
);

    logic [DEPTH-1:0] match_vec;

    // one comparator per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match_vec[g] = ent_valid[g] & ~ent_skip[g]
                            & (ent_addr[g*ADDR_W +: ADDR_W] == probe_addr);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx = IDX_W'(i);
        end
        hit = |match_vec;
    end

    // R3: mergeable slots never share an address
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

endmodule

// File: rtl/wbuf_bytemerge.sv
module wbuf_bytemerge #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTES  = DATA_W / 8
) (
    input  logic [DATA_W-1:0] old_data,
    input  logic [BYTES-1:0]  old_be,
    input  logic [DATA_W-1:0] new_data,
    input  logic [BYTES-1:0]  new_be,
    output logic [DATA_W-1:0] out_data,
    output logic [BYTES-1:0]  out_be
);

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign out_data[b*8 +: 8] = new_be[b] ? new_data[b*8 +: 8] :
                                    old_be[b] ? old_data[b*8 +: 8] : 8'h00;
    end

    assign out_be = old_be | new_be;

endmodule

// File: rtl/store_coalesce_buf.sv
module store_coalesce_buf #(
    parameter int unsigned DEPTH  = wbuf_pkg::WB_DEPTH_DFLT,
    parameter int unsigned ADDR_W = wbuf_pkg::WB_ADDR_W_DFLT,
    parameter int unsigned DATA_W = wbuf_pkg::WB_DATA_W_DFLT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [ADDR_W-1:0]     in_addr,
    input  logic [DATA_W-1:0]     in_data,
    input  logic [DATA_W/8-1:0]   in_be,
    output logic                  in_accept,
    output logic                  in_stall,
    output logic                  empty,
    output logic                  mem_valid,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_data,
    output logic [DATA_W/8-1:0]   mem_be,
    input  logic                  mem_ready
);

    localparam int unsigned BYTES = DATA_W / 8;
    localparam int unsigned IDX_W = wbuf_pkg::idx_width(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BYTES-1:0]  be;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
        logic [IDX_W-1:0]  head;
        logic [IDX_W-1:0]  tail;
        logic [CNT_W-1:0]  count;
    } state_t;

    state_t st_d, st_q;

    function automatic logic [IDX_W-1:0] step_ptr(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // matcher inputs
    logic [DEPTH-1:0]        valid_vec;
    logic [DEPTH-1:0]        skip_vec;
    logic [DEPTH*ADDR_W-1:0] addr_flat;
    logic                    hit;
    logic [IDX_W-1:0]        hit_idx;

    always_comb begin
        skip_vec = '0;
        skip_vec[st_q.head] = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            valid_vec[i]                 = st_q.slot[i].valid;
            addr_flat[i*ADDR_W +: ADDR_W] = st_q.slot[i].addr;
        end
    end

    wbuf_match #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) i_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .ent_valid  (valid_vec),
        .ent_skip   (skip_vec),
        .ent_addr   (addr_flat),
        .probe_addr (in_addr),
        .hit        (hit),
        .hit_idx    (hit_idx)
    );

    // merge source: hit slot, or nothing for a fresh slot
    logic [DATA_W-1:0] src_data;
    logic [BYTES-1:0]  src_be;
    logic [DATA_W-1:0] mrg_data;
    logic [BYTES-1:0]  mrg_be;

    always_comb begin
        src_data = hit ? st_q.slot[hit_idx].data : '0;
        src_be   = hit ? st_q.slot[hit_idx].be   : '0;
    end

    wbuf_bytemerge #(
        .DATA_W (DATA_W),
        .BYTES  (BYTES)
    ) i_merge (
        .old_data (src_data),
        .old_be   (src_be),
        .new_data (in_data),
        .new_be   (in_be),
        .out_data (mrg_data),
        .out_be   (mrg_be)
    );

    logic full;
    logic drain_fire;
    logic do_merge;
    logic do_alloc;

    always_comb begin
        full       = (st_q.count == CNT_W'(DEPTH));
        mem_valid  = st_q.slot[st_q.head].valid;
        mem_addr   = st_q.slot[st_q.head].addr;
        mem_data   = st_q.slot[st_q.head].data;
        mem_be     = st_q.slot[st_q.head].be;
        empty      = (st_q.count == '0);
        drain_fire = mem_valid & mem_ready;
        do_merge   = in_valid & hit;
        do_alloc   = in_valid & ~hit & (~full | drain_fire);
        in_accept  = do_merge | do_alloc;
        in_stall   = in_valid & ~in_accept;

        st_d = st_q;
        if (drain_fire) begin
            st_d.slot[st_q.head].valid = 1'b0;
            st_d.head                  = step_ptr(st_q.head);
        end
        if (do_merge) begin
            st_d.slot[hit_idx].data = mrg_data;
            st_d.slot[hit_idx].be   = mrg_be;
        end else if (do_alloc) begin
            st_d.slot[st_q.tail].valid = 1'b1;
            st_d.slot[st_q.tail].addr  = in_addr;
            st_d.slot[st_q.tail].data  = mrg_data;
            st_d.slot[st_q.tail].be    = mrg_be;
            st_d.tail                  = step_ptr(st_q.tail);
        end
        case ({do_alloc, drain_fire})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    free_slot_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && st_q.count < CNT_W'(DEPTH)) |-> in_accept);

    // R6
    stall_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_stall |-> (st_q.count == CNT_W'(DEPTH)));

    // R5
    hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_data) && $stable(mem_be)));

    // R8
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !mem_valid);

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!in_accept && !in_stall));

endmodule

// File: tb/test_store_coalesce_buf.sv
`timescale 1ns/1ps
module test_store_coalesce_buf;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [29:0] in_addr;
    logic [31:0] in_data;
    logic [3:0]  in_be;
    logic        in_accept, in_stall, empty;
    logic        mem_valid;
    logic [29:0] mem_addr;
    logic [31:0] mem_data;
    logic [3:0]  mem_be;
    logic        mem_ready;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    store_coalesce_buf i_store_coalesce_buf (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_data(in_data), .in_be(in_be), .in_accept(in_accept),
        .in_stall(in_stall), .empty(empty), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
        .mem_ready(mem_ready)
    );

    typedef struct packed {
        logic        vld;
        logic [29:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic        exp_acc;
        logic        exp_stall;
        logic        exp_empty;
    } vec_t;

    // mem_ready held low for the whole table
    localparam vec_t VECS [8] = '{
        '{1'b1, 30'h10, 32'h11111111, 4'hF, 1'b1, 1'b0, 1'b1}, // R2 first write
        '{1'b1, 30'h10, 32'h22222222, 4'h1, 1'b1, 1'b0, 1'b0}, // R4 same addr as oldest
        '{1'b1, 30'h10, 32'h0000AA00, 4'h2, 1'b1, 1'b0, 1'b0}, // R3 merge
        '{1'b1, 30'h20, 32'h33333333, 4'hF, 1'b1, 1'b0, 1'b0}, // R2
        '{1'b1, 30'h30, 32'h4444FFFF, 4'hC, 1'b1, 1'b0, 1'b0}, // R2 fills
        '{1'b1, 30'h40, 32'h99999999, 4'hF, 1'b0, 1'b1, 1'b0}, // R6 stall
        '{1'b1, 30'h20, 32'h000000EE, 4'h1, 1'b1, 1'b0, 1'b0}, // R6 merge when full
        '{1'b0, 30'h00, 32'h00000000, 4'h0, 1'b0, 1'b0, 1'b0}  // R10 idle
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [29:0] a, input logic [31:0] d,
                         input logic [3:0] b, input logic rdy);
        @(negedge clk);
        in_valid  = v;
        in_addr   = a;
        in_data   = d;
        in_be     = b;
        mem_ready = rdy;
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_data = '0;
        in_be = '0; mem_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 empty", empty, 1);
        chk("R1 mem_valid", mem_valid, 0);
        chk("R1 stall", in_stall, 0);

        for (int i = 0; i < 8; i++) begin
            drive(VECS[i].vld, VECS[i].addr, VECS[i].data, VECS[i].be, 1'b0);
            chk("R2/R6 accept", in_accept, VECS[i].exp_acc);
            chk("R6/R10 stall", in_stall, VECS[i].exp_stall);
            chk("R8 empty", empty, VECS[i].exp_empty);
        end

        // oldest slot offered and held while not ready
        drive(1'b0, '0, '0, '0, 1'b0);
        chk("R4 head addr", mem_addr, 30'h10);
        chk("R4 head data", mem_data, 32'h11111111);
        chk("R5 head valid", mem_valid, 1);

        // full, write and drain in the same cycle
        drive(1'b1, 30'h50, 32'h55555555, 4'hF, 1'b1);
        chk("R7 accept", in_accept, 1);
        chk("R7 stall", in_stall, 0);
        chk("R5 held data", mem_data, 32'h11111111);
        chk("R5 held be", mem_be, 4'hF);

        // drain remaining slots in order
        drive(1'b0, '0, '0, '0, 1'b1);
        chk("R3 addr", mem_addr, 30'h10);
        chk("R3 data", mem_data, 32'h0000AA22);
        chk("R3 be", mem_be, 4'h3);
        drive(1'b0, '0, '0, '0, 1'b1);
        chk("R5 order addr", mem_addr, 30'h20);
        chk("R3 merged data", mem_data, 32'h333333EE);
        drive(1'b0, '0, '0, '0, 1'b1);
        chk("R5 order addr", mem_addr, 30'h30);
        chk("R9 masked data", mem_data, 32'h44440000);
        chk("R9 be", mem_be, 4'hC);
        drive(1'b0, '0, '0, '0, 1'b1);
        chk("R7 new slot addr", mem_addr, 30'h50);
        chk("R7 new slot data", mem_data, 32'h55555555);
        chk("R8 not empty", empty, 0);
        drive(1'b0, '0, '0, '0, 1'b1);
        chk("R8 empty", empty, 1);
        chk("R8 mem_valid", mem_valid, 0);

        // reset clears held state
        drive(1'b1, 30'h60, 32'h1, 4'h1, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 empty after reset", empty, 1);
        chk("R1 mem_valid after reset", mem_valid, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule